// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Status

This block receives asynchronous serial characters on a single input line and keeps up to two finished characters: one in a receive buffer that software reads, and one waiting in the shift stage behind it. A fixed oversampling counter times every bit, and each bit is sampled at its centre. A start edge only counts as a start bit if the line is still low at the middle of that bit.

Every character carries its own parity-error, frame-error and overflow flags. Those flags move with the character, so the status register always describes the character that the next data read will return. Software reads the status and data registers through a small register port. It clears flags by writing ones to the status register. Dropping the receiver enable wipes every stored flag.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status register (offset 0x10) reads 0x0000 and `rx_ready` is 0.
- R2: A frame is a low start bit, 8 data bits sent LSB first, an optional parity bit and one stop bit. Each bit lasts OVERSAMPLE*TICK_DIV clocks and is sampled at its middle. Reading offset 0x14 returns the buffered character in bits 7:0 and removes it from the buffer.
- R3: When `parity_en` is 1, the frame carries an even-parity bit after the data. If that bit differs from the XOR of the 8 data bits, status bit 0 is set for that character. With `parity_en` at 0, bit 0 is never set.
- R4: A stop bit sampled as 0 sets status bit 1 for that character.
- R5: Writing a 1 to a status bit at offset 0x10 clears that bit, and writing a 0 leaves it unchanged.
- R6: Flags are stored per character. The status register shows the flags of the buffered character. When that character is read, a waiting character moves into the buffer together with its own flags. When no character is buffered, the status reads 0.
- R7: Status bit 2 (overflow) is set on the buffered character only when the buffer is full, a finished character is waiting, and a new start bit is confirmed. That new frame is discarded.
- R8: While `rx_en` is 0, every stored error flag is cleared and the receiver stays idle.
- R9: A low pulse that has ended by the middle of the start bit is ignored. It loads no character.
- R10: `rx_ready` is 1 exactly while a character is held in the receive buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low clears all flags |
| parity_en | input | 1 | Frame carries an even-parity bit |
| rxd | input | 1 | Serial line, idle high |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rd | input | 1 | Register read strobe (pops data at 0x14) |
| reg_rdata | output | REG_W | Read data for reg_addr |
| rx_ready | output | 1 | Receive buffer holds a character |

## Verification
The assertions check on every cycle that an empty buffer carries no flags and that a waiting character implies a full buffer. They also check that the overflow flag only rises when both storage stages were full, and that a low enable leaves no flag behind. The bench scenarios are needed for everything that depends on line timing and data values: LSB-first assembly, parity and stop-bit detection, glitch rejection, flags following characters through a read, and which character is lost on overflow.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV = 2,
  parameter int DATA_BITS = 8,
  parameter int ADDR_W = 5,
  parameter int REG_W = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h10,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              parity_en,
  input  logic              rxd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              rx_ready
);
  localparam int BIT_CLKS = OVERSAMPLE * TICK_DIV;
  localparam int HALF = BIT_CLKS / 2;
  localparam int CNT_W = $clog2(BIT_CLKS);
  localparam int BI_W = $clog2(DATA_BITS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t st;
  logic [CNT_W-1:0] cnt;
  logic [BI_W-1:0] bidx;
  logic [DATA_BITS-1:0] asm_q;
  logic par_bad, rxd_q;

  logic buf_full, hold_full;
  logic [DATA_BITS-1:0] buf_dat, hold_dat;
  logic [2:0] buf_flg, hold_flg;

  logic bit_last, half_last, done, confirm, pop, clr_wr;
  logic [2:0] done_flg;

  assign bit_last  = cnt == CNT_W'(BIT_CLKS - 1);
  assign half_last = cnt == CNT_W'(HALF - 1);
  assign done      = rx_en && st == S_STOP && bit_last;
  assign confirm   = rx_en && st == S_START && half_last && !rxd;
  assign done_flg  = {1'b0, !rxd, par_bad};
  assign pop       = reg_rd && reg_addr == DATA_ADDR && buf_full;
  assign clr_wr    = reg_wr && reg_addr == STATUS_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bidx <= '0;
      asm_q <= '0;
      par_bad <= 1'b0;
      rxd_q <= 1'b1;
    end else begin
      rxd_q <= rxd;
      if (!rx_en) begin
        st <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (rxd_q && !rxd) begin
            st <= S_START;
            cnt <= '0;
          end
          S_START: if (half_last) begin
            cnt <= '0;
            bidx <= '0;
            par_bad <= 1'b0;
            st <= rxd ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
          S_DATA: if (bit_last) begin
            cnt <= '0;
            asm_q <= {rxd, asm_q[DATA_BITS-1:1]};
            if (bidx == BI_W'(DATA_BITS - 1)) st <= parity_en ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (bit_last) begin
            cnt <= '0;
            par_bad <= rxd != (^asm_q);
            st <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (bit_last) begin
            cnt <= '0;
            st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic b_full_n, h_full_n;
  logic [DATA_BITS-1:0] b_dat_n, h_dat_n;
  logic [2:0] b_flg_n, h_flg_n;

  always_comb begin
    b_full_n = buf_full;  b_dat_n = buf_dat;  b_flg_n = buf_flg;
    h_full_n = hold_full; h_dat_n = hold_dat; h_flg_n = hold_flg;
    if (pop) begin
      if (hold_full) begin
        b_dat_n = hold_dat;
        b_flg_n = hold_flg;
        h_full_n = 1'b0;
        h_flg_n = '0;
      end else begin
        b_full_n = 1'b0;
        b_flg_n = '0;
      end
    end
    if (done) begin
      if (!b_full_n) begin
        b_full_n = 1'b1;
        b_dat_n = asm_q;
        b_flg_n = done_flg;
      end else if (!h_full_n) begin
        h_full_n = 1'b1;
        h_dat_n = asm_q;
        h_flg_n = done_flg;
      end
    end
    if (confirm && buf_full && hold_full && !pop) b_flg_n[2] = 1'b1;
    if (clr_wr) b_flg_n = b_flg_n & ~reg_wdata[2:0];
    if (!rx_en) begin
      b_flg_n = '0;
      h_flg_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;  buf_dat <= '0;  buf_flg <= '0;
      hold_full <= 1'b0; hold_dat <= '0; hold_flg <= '0;
    end else begin
      buf_full <= b_full_n;  buf_dat <= b_dat_n;  buf_flg <= b_flg_n;
      hold_full <= h_full_n; hold_dat <= h_dat_n; hold_flg <= h_flg_n;
    end
  end

  assign rx_ready = buf_full;
  assign reg_rdata = (reg_addr == STATUS_ADDR) ? {{(REG_W-3){1'b0}}, buf_flg} :
                     (reg_addr == DATA_ADDR)   ? {{(REG_W-DATA_BITS){1'b0}}, buf_dat} :
                     '0;
endmodule

module uart_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       buf_full,
  input logic       hold_full,
  input logic [2:0] buf_flg,
  input logic [2:0] hold_flg
);
  assert_empty_no_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_full |-> buf_flg == 3'b000);

  assert_hold_needs_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> buf_full);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_flg[2]) |-> $past(buf_full && hold_full));

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (buf_flg == 3'b000 && hold_flg == 3'b000));
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .buf_full(buf_full),
  .hold_full(hold_full), .buf_flg(buf_flg), .hold_flg(hold_flg)
);

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  localparam int BIT_CLKS = 32;
  localparam logic [4:0] ST = 5'h10;
  localparam logic [4:0] DT = 5'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rx_en = 1'b1, parity_en = 1'b0, rxd = 1'b1;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic rx_ready;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  uart_rx_status #(.OVERSAMPLE(16), .TICK_DIV(2)) u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .parity_en(parity_en), .rxd(rxd),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .rx_ready(rx_ready)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic line_bit(logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic with_par, logic bad_par, logic stop);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(d[i]);
    if (with_par) line_bit((^d) ^ bad_par);
    line_bit(stop);
    line_bit(1'b1);
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(ST, v);
    check("R1 status after reset", v, 16'h0000);
    check("R1 ready after reset", {15'b0, rx_ready}, 16'h0000);
  endtask

  task automatic t_basic;
    logic [15:0] v;
    send(8'hA5, 0, 0, 1);
    check("R10 ready after char", {15'b0, rx_ready}, 16'h0001);
    rd(ST, v); check("R2 status clean char", v, 16'h0000);
    rd(DT, v); check("R2 data A5", v, 16'h00A5);
    check("R10 ready after pop", {15'b0, rx_ready}, 16'h0000);
    send(8'h01, 0, 0, 1);
    rd(DT, v); check("R2 LSB first 01", v, 16'h0001);
    send(8'h80, 0, 0, 1);
    rd(DT, v); check("R2 LSB first 80", v, 16'h0080);
  endtask

  task automatic t_parity;
    logic [15:0] v;
    parity_en = 1'b1;
    send(8'h37, 1, 0, 1);
    rd(ST, v); check("R3 good parity", v, 16'h0000);
    rd(DT, v); check("R3 data with parity", v, 16'h0037);
    send(8'h37, 1, 1, 1);
    rd(ST, v); check("R3 bad parity flag", v, 16'h0001);
    rd(DT, v); check("R3 data bad parity", v, 16'h0037);
    parity_en = 1'b0;
  endtask

  task automatic t_frame_w1c;
    logic [15:0] v;
    parity_en = 1'b1;
    send(8'h5A, 1, 1, 0);
    rd(ST, v); check("R4 frame and parity flags", v, 16'h0003);
    wr(ST, 16'h0000);
    rd(ST, v); check("R5 write zero no effect", v, 16'h0003);
    wr(ST, 16'h0001);
    rd(ST, v); check("R5 clear parity only", v, 16'h0002);
    wr(ST, 16'h0002);
    rd(ST, v); check("R5 clear frame", v, 16'h0000);
    rd(DT, v); check("R4 data kept", v, 16'h005A);
    parity_en = 1'b0;
  endtask

  task automatic t_per_char;
    logic [15:0] v;
    send(8'h11, 0, 0, 0);
    send(8'h22, 0, 0, 1);
    rd(ST, v); check("R6 first char flags", v, 16'h0002);
    rd(DT, v); check("R6 first data", v, 16'h0011);
    rd(ST, v); check("R6 second char flags", v, 16'h0000);
    rd(DT, v); check("R6 second data", v, 16'h0022);
    rd(ST, v); check("R6 empty status", v, 16'h0000);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    send(8'hC1, 0, 0, 1);
    send(8'hC2, 0, 0, 1);
    rd(ST, v); check("R7 no overflow with two chars", v, 16'h0000);
    send(8'hC3, 0, 0, 1);
    rd(ST, v); check("R7 overflow flag", v, 16'h0004);
    rd(DT, v); check("R7 oldest data", v, 16'h00C1);
    rd(ST, v); check("R7 waiting char clean", v, 16'h0000);
    rd(DT, v); check("R7 waiting data", v, 16'h00C2);
    check("R7 third char dropped", {15'b0, rx_ready}, 16'h0000);
  endtask

  task automatic t_disable;
    logic [15:0] v;
    send(8'h44, 0, 0, 0);
    send(8'h55, 0, 0, 0);
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk); rx_en = 1'b1;
    rd(ST, v); check("R8 buffer flags cleared", v, 16'h0000);
    rd(DT, v); check("R8 data kept", v, 16'h0044);
    rd(ST, v); check("R8 waiting flags cleared", v, 16'h0000);
    rd(DT, v); check("R8 second data kept", v, 16'h0055);
  endtask

  task automatic t_glitch;
    logic [15:0] v;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check("R9 glitch ignored", {15'b0, rx_ready}, 16'h0000);
    send(8'h3C, 0, 0, 1);
    rd(DT, v); check("R9 frame after glitch", v, 16'h003C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_frame_w1c();
    t_per_char();
    t_overflow();
    t_disable();
    t_glitch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule